// File: doc/BRIEF.md
# Programmable Region Address Decoder

This block sits between a CPU's access path and three downstream ports: the DRAM controller, a general-purpose external bus and the PCI bus. It looks at each access and decides where the access goes. Without any programming, memory below a configurable DRAM ceiling goes to DRAM, and all other memory goes to PCI. I/O ports at 0x400 and above go to PCI. Ports below 0x400 go to the external bus, or to PCI when a control bit redirects this low I/O hole.

A bank of region registers can override the default routing. Each register names a target, three attribute bits, a page granularity (4 KB or 64 KB), a page count and a start page. When several regions match, the lowest-numbered one wins. Only regions 0 and 1 may name a PCI target. This lets them open a PCI window inside DRAM space, such as a legacy video aperture at 0xA0000–0xBFFFF.

Software programs the bank through a simple indexed write/read port. The decision is registered and appears one cycle after a valid request. It is a one-hot destination together with the index of the winning region, or a no-hit flag.

Top module: `rgn_dec`

## Requirements
- R1: A memory access whose bits [31:16] are below the DRAM ceiling, and that no region claims, routes to DRAM (dstOneHot = 3'b001), with regionHit = 0 and dstAttr = 0.
- R2: A memory access whose bits [31:16] are at or above the DRAM ceiling, and that no region claims, routes to PCI (dstOneHot = 3'b100).
- R3: An unclaimed I/O access uses only address bits [15:0]. A port at or above 0x400 routes to PCI. A port below 0x400 routes to the external bus (dstOneHot = 3'b010) while the hole-redirect bit is clear.
- R4: Control register bit 31 is the hole-redirect bit. While it is set, unclaimed I/O ports below 0x400 route to PCI.
- R5: An I/O region covering low ports takes priority over the hole-redirect bit.
- R6: Region register layout: [31:29] target, [28:26] attributes, [25] granularity (1 = 64 KB, 0 = 4 KB), [24:18] size, [17:0] start. A memory region matches when start ≤ page(addr) ≤ start + size. An I/O region matches when start[15:0] ≤ port ≤ start[15:0] + size, in bytes.
- R7: Target codes: 001 = external bus I/O, 010 = external bus memory, 011 = PCI memory, 100 = DRAM memory, 101 = PCI I/O. Codes 000, 110 and 111 disable the region. A memory code matches only memory accesses, and an I/O code matches only I/O accesses.
- R8: Codes 011 and 101 in any region numbered 2 or above never match, so such an access falls through to default routing.
- R9: When several regions match, the lowest-numbered region sets the destination, regionIdx and dstAttr.
- R10: A hit on a PCI target reports dstAttr = 0, whatever the attribute field holds. A hit on any other target reports that region's attribute field.
- R11: The outputs of a request sampled at one clock edge appear after that edge. In a cycle after no request, dstValid, dstOneHot, regionHit, regionIdx and dstAttr are all 0. While dstValid is 1, dstOneHot has exactly one bit set.
- R12: Indices 0..7 address the region registers and index 8 addresses the control register (bit 31 hole-redirect, bits [15:0] DRAM ceiling in 64 KB units). Reset clears the regions and the hole bit and sets the ceiling to 0x0100. Read data follows regAddr at once. Writes to indices above 8 change nothing and read back as 0. A write takes effect for requests in later cycles.
- R13: With region 0 = 0x6204000A, memory at 0xA0000 and 0xBFFFF routes to PCI with a hit on region 0, while 0x9FFFF and 0xC0000 still route to DRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register index (0..7 regions, 8 control) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| reqValid | input | 1 | Access request valid |
| reqAddr | input | 32 | Access address |
| reqIsIo | input | 1 | 1 = I/O access, 0 = memory access |
| dstValid | output | 1 | Registered decision valid |
| dstOneHot | output | 3 | Destination: bit0 DRAM, bit1 external bus, bit2 PCI |
| regionHit | output | 1 | A region register claimed the access |
| regionIdx | output | 3 | Index of the winning region (0 when no hit) |
| dstAttr | output | 3 | Attribute bits of the winning region |

## Verification
A corrupted region register or control bit shows up in the first decision after the corruption. It appears as a wrong destination bit, a wrong regionIdx or a spurious hit flag, and it is also visible at once on regRdata for the selected index. A broken priority scan or bound comparison only shows when an address lands on an overlap or on the first or last page of a window. For that reason, the stimulus sits on each region edge and one step outside it. A stuck pipeline register shows as dstValid or stale fields in the idle cycle that follows a request.

// File: rtl/rgn_dec_pkg.sv
package rgn_dec_pkg;

  // access and register geometry
  localparam int ADDR_W      = 32;
  localparam int REG_W       = 32;
  localparam int IO_W        = 16;
  localparam int IO_HOLE_TOP = 1024;

  // region register fields
  localparam int TGT_LSB   = 29;
  localparam int ATTR_LSB  = 26;
  localparam int PGSEL_BIT = 25;
  localparam int SIZE_LSB  = 18;
  localparam int SIZE_W    = 7;
  localparam int START_W   = 18;

  // page shifts for the two granularities
  localparam int SMALL_PG_SH = 12;
  localparam int LARGE_PG_SH = 16;

  // control register fields
  localparam int DTOP_W       = ADDR_W - LARGE_PG_SH;
  localparam int CTL_HOLE_BIT = 31;

  // regions allowed to name a PCI target
  localparam int PCI_RGN_CNT = 2;

  // target codes
  localparam logic [2:0] TGT_EXT_IO   = 3'b001;
  localparam logic [2:0] TGT_EXT_MEM  = 3'b010;
  localparam logic [2:0] TGT_PCI_MEM  = 3'b011;
  localparam logic [2:0] TGT_DRAM_MEM = 3'b100;
  localparam logic [2:0] TGT_PCI_IO   = 3'b101;

  // one-hot destinations
  localparam logic [2:0] DST_NONE = 3'b000;
  localparam logic [2:0] DST_DRAM = 3'b001;
  localparam logic [2:0] DST_EXT  = 3'b010;
  localparam logic [2:0] DST_PCI  = 3'b100;

  typedef struct packed {
    logic load;   // capture a new decision
    logic clear;  // drop the output to idle
  } strobe_t;

endpackage

// File: rtl/rgn_dec_match.sv
module rgn_dec_match
  import rgn_dec_pkg::*;
#(
  parameter bit PCI_OK = 1'b1
) (
  input  logic [REG_W-1:0]  rgnVal,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsIo,
  output logic              hit,
  output logic [2:0]        dst,
  output logic [2:0]        attr
);

  localparam int SPG_W = ADDR_W - SMALL_PG_SH;
  localparam int CMP_W = ((SPG_W > START_W) ? SPG_W : START_W) + 1;

  logic [2:0]       tgt;
  logic             enabled;
  logic             ioTgt;
  logic [CMP_W-1:0] pageNum;
  logic [CMP_W-1:0] pageLo;
  logic [CMP_W-1:0] pageHi;
  logic [IO_W:0]    portNum;
  logic [IO_W:0]    portLo;
  logic [IO_W:0]    portHi;
  logic             inRange;

  // target decode
  always_comb begin
    tgt     = rgnVal[TGT_LSB +: 3];
    enabled = 1'b1;
    ioTgt   = 1'b0;
    dst     = DST_NONE;
    case (tgt)
      TGT_EXT_IO:   begin ioTgt = 1'b1; dst = DST_EXT; end
      TGT_EXT_MEM:  dst = DST_EXT;
      TGT_PCI_MEM:  begin dst = DST_PCI; enabled = PCI_OK; end
      TGT_DRAM_MEM: dst = DST_DRAM;
      TGT_PCI_IO:   begin ioTgt = 1'b1; dst = DST_PCI; enabled = PCI_OK; end
      default:      enabled = 1'b0;
    endcase
  end

  // bound compare
  always_comb begin
    pageNum = rgnVal[PGSEL_BIT] ? CMP_W'(reqAddr >> LARGE_PG_SH)
                                : CMP_W'(reqAddr >> SMALL_PG_SH);
    pageLo  = CMP_W'(rgnVal[START_W-1:0]);
    pageHi  = pageLo + CMP_W'(rgnVal[SIZE_LSB +: SIZE_W]);
    portNum = {1'b0, reqAddr[IO_W-1:0]};
    portLo  = {1'b0, rgnVal[IO_W-1:0]};
    portHi  = portLo + (IO_W+1)'(rgnVal[SIZE_LSB +: SIZE_W]);
    inRange = reqIsIo ? ((portNum >= portLo) && (portNum <= portHi))
                      : ((pageNum >= pageLo) && (pageNum <= pageHi));
    hit     = enabled && (ioTgt == reqIsIo) && inRange;
    attr    = (dst == DST_PCI) ? 3'b000 : rgnVal[ATTR_LSB +: 3];
  end

endmodule

// File: rtl/rgn_dec_ctrl.sv
module rgn_dec_ctrl
  import rgn_dec_pkg::*;
#(
  parameter int              NUM_RGN      = 8,
  parameter int              AIDX_W       = 4,
  parameter logic [DTOP_W-1:0] DRAM_TOP_RST = 16'h0100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          regWe,
  input  logic [AIDX_W-1:0]             regAddr,
  input  logic [REG_W-1:0]              regWdata,
  output logic [REG_W-1:0]              regRdata,
  input  logic                          reqValid,
  output strobe_t                       strobe,
  output logic [NUM_RGN-1:0][REG_W-1:0] rgnBank,
  output logic                          ioHoleToPci,
  output logic [DTOP_W-1:0]             dramTopPg
);

  localparam logic [AIDX_W-1:0] CTL_IDX = AIDX_W'(NUM_RGN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgnBank     <= '0;
      ioHoleToPci <= 1'b0;
      dramTopPg   <= DRAM_TOP_RST;
    end else if (regWe) begin
      for (int i = 0; i < NUM_RGN; i++) begin
        if (regAddr == AIDX_W'(i)) rgnBank[i] <= regWdata;
      end
      if (regAddr == CTL_IDX) begin
        ioHoleToPci <= regWdata[CTL_HOLE_BIT];
        dramTopPg   <= regWdata[DTOP_W-1:0];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_RGN; i++) begin
      if (regAddr == AIDX_W'(i)) regRdata = rgnBank[i];
    end
    if (regAddr == CTL_IDX) begin
      regRdata                    = REG_W'(dramTopPg);
      regRdata[CTL_HOLE_BIT]      = ioHoleToPci;
    end
  end

  always_comb begin
    strobe.load  = reqValid;
    strobe.clear = !reqValid;
  end

  // R12
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regWe && (regAddr > CTL_IDX)) |=> ($stable(rgnBank) && $stable(ioHoleToPci) && $stable(dramTopPg)));

endmodule

// File: rtl/rgn_dec_dp.sv
module rgn_dec_dp
  import rgn_dec_pkg::*;
#(
  parameter int NUM_RGN = 8,
  parameter int RIDX_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  strobe_t                       strobe,
  input  logic [NUM_RGN-1:0][REG_W-1:0] rgnBank,
  input  logic                          ioHoleToPci,
  input  logic [DTOP_W-1:0]             dramTopPg,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic                          reqIsIo,
  output logic                          dstValid,
  output logic [2:0]                    dstOneHot,
  output logic                          regionHit,
  output logic [RIDX_W-1:0]             regionIdx,
  output logic [2:0]                    dstAttr
);

  logic [NUM_RGN-1:0] hitVec;
  logic [2:0]         dstVec  [NUM_RGN];
  logic [2:0]         attrVec [NUM_RGN];

  generate
    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
      rgn_dec_match #(
        .PCI_OK (g < PCI_RGN_CNT)
      ) u_match (
        .rgnVal  (rgnBank[g]),
        .reqAddr (reqAddr),
        .reqIsIo (reqIsIo),
        .hit     (hitVec[g]),
        .dst     (dstVec[g]),
        .attr    (attrVec[g])
      );
    end
  endgenerate

  logic              selHit;
  logic [RIDX_W-1:0] selIdx;
  logic [2:0]        selDst;
  logic [2:0]        selAttr;
  logic [2:0]        memDefault;
  logic [2:0]        ioDefault;
  logic [2:0]        nextDst;

  // lowest index wins: scan downward, last assignment stands
  always_comb begin
    selHit  = 1'b0;
    selIdx  = '0;
    selDst  = DST_NONE;
    selAttr = 3'b000;
    for (int i = NUM_RGN - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selHit  = 1'b1;
        selIdx  = RIDX_W'(i);
        selDst  = dstVec[i];
        selAttr = attrVec[i];
      end
    end
  end

  always_comb begin
    memDefault = (reqAddr[ADDR_W-1:LARGE_PG_SH] < dramTopPg) ? DST_DRAM : DST_PCI;
    if (reqAddr[IO_W-1:0] >= IO_W'(IO_HOLE_TOP)) ioDefault = DST_PCI;
    else                                         ioDefault = ioHoleToPci ? DST_PCI : DST_EXT;
    if (selHit)       nextDst = selDst;
    else if (reqIsIo) nextDst = ioDefault;
    else              nextDst = memDefault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dstValid  <= 1'b0;
      dstOneHot <= DST_NONE;
      regionHit <= 1'b0;
      regionIdx <= '0;
      dstAttr   <= 3'b000;
    end else if (strobe.load) begin
      dstValid  <= 1'b1;
      dstOneHot <= nextDst;
      regionHit <= selHit;
      regionIdx <= selIdx;
      dstAttr   <= selAttr;
    end else if (strobe.clear) begin
      dstValid  <= 1'b0;
      dstOneHot <= DST_NONE;
      regionHit <= 1'b0;
      regionIdx <= '0;
      dstAttr   <= 3'b000;
    end
  end

  // R11
  onehot_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dstValid |-> ($countones(dstOneHot) == 1));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dstValid |-> ((dstOneHot == DST_NONE) && !regionHit && (dstAttr == 3'b000)));

  // R8
  pci_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dstValid && regionHit && (dstOneHot == DST_PCI)) |-> (int'(regionIdx) < PCI_RGN_CNT));

  // R10
  pci_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dstValid && (dstOneHot == DST_PCI)) |-> (dstAttr == 3'b000));

endmodule

// File: rtl/rgn_dec.sv
module rgn_dec
  import rgn_dec_pkg::*;
#(
  parameter int                NUM_RGN      = 8,
  parameter logic [DTOP_W-1:0] DRAM_TOP_RST = 16'h0100,
  localparam int               AIDX_W       = $clog2(NUM_RGN + 1),
  localparam int               RIDX_W       = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [AIDX_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsIo,
  output logic              dstValid,
  output logic [2:0]        dstOneHot,
  output logic              regionHit,
  output logic [RIDX_W-1:0] regionIdx,
  output logic [2:0]        dstAttr
);

  strobe_t                       strobe;
  logic [NUM_RGN-1:0][REG_W-1:0] rgnBank;
  logic                          ioHoleToPci;
  logic [DTOP_W-1:0]             dramTopPg;

  rgn_dec_ctrl #(
    .NUM_RGN      (NUM_RGN),
    .AIDX_W       (AIDX_W),
    .DRAM_TOP_RST (DRAM_TOP_RST)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .regWe       (regWe),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .reqValid    (reqValid),
    .strobe      (strobe),
    .rgnBank     (rgnBank),
    .ioHoleToPci (ioHoleToPci),
    .dramTopPg   (dramTopPg)
  );

  rgn_dec_dp #(
    .NUM_RGN (NUM_RGN),
    .RIDX_W  (RIDX_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .rgnBank     (rgnBank),
    .ioHoleToPci (ioHoleToPci),
    .dramTopPg   (dramTopPg),
    .reqAddr     (reqAddr),
    .reqIsIo     (reqIsIo),
    .dstValid    (dstValid),
    .dstOneHot   (dstOneHot),
    .regionHit   (regionHit),
    .regionIdx   (regionIdx),
    .dstAttr     (dstAttr)
  );

  // R11
  req_to_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> dstValid);

endmodule

// File: tb/rgn_dec_tb.sv
module rgn_dec_tb;

  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqIsIo = 1'b0;
  logic        dstValid;
  logic [2:0]  dstOneHot;
  logic        regionHit;
  logic [2:0]  regionIdx;
  logic [2:0]  dstAttr;

  always #10 clk = ~clk;

  rgn_dec #(.NUM_RGN(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqIsIo(reqIsIo), .dstValid(dstValid),
    .dstOneHot(dstOneHot), .regionHit(regionHit), .regionIdx(regionIdx),
    .dstAttr(dstAttr)
  );

  int    testsRun = 0;
  int    testsFailed = 0;
  bit    checking = 0;
  string curTag = "R12";
  string expTag = "R11";

  // behavioural model state
  logic [31:0] mRgn [NR];
  logic        mHole;
  logic [15:0] mTop;
  logic        eValid;
  logic [2:0]  eDst;
  logic        eHit;
  logic [2:0]  eIdx;
  logic [2:0]  eAttr;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic refRoute(input logic [31:0] a, input logic io);
    eHit = 0; eIdx = 0; eAttr = 0; eDst = 0;
    for (int i = 0; i < NR; i++) begin
      int tgt; int sz; bit wantIo; bit ok;
      longint lo; longint hi; longint p; longint unit;
      tgt = int'(mRgn[i][31:29]);
      sz  = int'(mRgn[i][24:18]);
      ok  = (tgt >= 1 && tgt <= 5) && !((tgt == 3 || tgt == 5) && i >= 2);
      wantIo = (tgt == 1 || tgt == 5);
      if (io) begin
        lo = longint'(mRgn[i][15:0]); hi = lo + sz; p = longint'(a[15:0]);
      end else begin
        unit = mRgn[i][25] ? 65536 : 4096;
        lo = longint'(mRgn[i][17:0]) * unit;
        hi = lo + (sz + 1) * unit - 1;
        p  = longint'(a);
      end
      if (!eHit && ok && (wantIo == io) && p >= lo && p <= hi) begin
        eHit  = 1;
        eIdx  = 3'(i);
        eDst  = (tgt == 4) ? 3'b001 : ((tgt == 3 || tgt == 5) ? 3'b100 : 3'b010);
        eAttr = (eDst == 3'b100) ? 3'b000 : mRgn[i][28:26];
      end
    end
    if (!eHit) begin
      if (io) eDst = (a[15:0] >= 16'd1024 || mHole) ? 3'b100 : 3'b010;
      else    eDst = (a[31:16] < mTop) ? 3'b001 : 3'b100;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) mRgn[i] = '0;
      mHole = 0; mTop = 16'h0100;
      eValid = 0; eDst = 0; eHit = 0; eIdx = 0; eAttr = 0;
    end else begin
      eValid = reqValid;
      if (reqValid) begin
        refRoute(reqAddr, reqIsIo);
        expTag = curTag;
      end else begin
        eDst = 0; eHit = 0; eIdx = 0; eAttr = 0;
        expTag = "R11";
      end
      if (regWe) begin
        if (regAddr < NR) mRgn[regAddr[2:0]] = regWdata;
        else if (regAddr == NR) begin mHole = regWdata[31]; mTop = regWdata[15:0]; end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && checking) begin
      logic [31:0] actV; logic [31:0] expV; logic [31:0] expR;
      actV = {21'd0, dstValid, dstOneHot, regionHit, regionIdx, dstAttr};
      expV = {21'd0, eValid, eDst, eHit, eIdx, eAttr};
      check(actV == expV, expTag, actV, expV);
      if (regAddr < NR)       expR = mRgn[regAddr[2:0]];
      else if (regAddr == NR) expR = {mHole, 15'd0, mTop};
      else                    expR = '0;
      check(regRdata == expR, "R12", regRdata, expR);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    #1; regWe = 1; regAddr = 4'(a); regWdata = d; reqValid = 0;
    @(negedge clk);
    #1; regWe = 0;
  endtask

  task automatic rq(input logic [31:0] a, input logic io, input string tag);
    #1; curTag = tag; regWe = 0; reqValid = 1; reqAddr = a; reqIsIo = io;
    @(negedge clk);
    #1; reqValid = 0;
  endtask

  task automatic sel(input int a);
    #1; regAddr = 4'(a);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL R11 watchdog: actual 20000 cycles expected end of sequence");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state seen at the ports
    check({dstValid, dstOneHot, regionHit, dstAttr} == '0, "R12", {dstValid, dstOneHot, regionHit, dstAttr}, 0);
    check(regRdata == 32'h0, "R12", regRdata, 32'h0);
    #1; rst_n = 1;
    @(negedge clk);
    checking = 1;
    sel(8);  // R12 ceiling reset value readback

    // R1 / R2 default memory routing
    rq(32'h0000_0000, 0, "R1");
    rq(32'h00FF_FFFF, 0, "R1");
    rq(32'h0100_0000, 0, "R2");
    rq(32'hFFFE_FFFF, 0, "R2");
    // R3 default I/O routing
    rq(32'h0000_03FF, 1, "R3");
    rq(32'h0000_0400, 1, "R3");
    rq(32'h0000_FFFF, 1, "R3");
    rq(32'h1234_0010, 1, "R3");
    sel(0);

    // R13 PCI window in DRAM space
    wr(0, 32'h6204_000A);
    rq(32'h000A_0000, 0, "R13");
    rq(32'h000B_FFFF, 0, "R13");
    rq(32'h0009_FFFF, 0, "R13");
    rq(32'h000C_0000, 0, "R13");
    // R10 attribute field ignored on PCI target
    wr(0, 32'h7E04_000A);
    rq(32'h000A_8000, 0, "R10");

    // R6 / R7 PCI I/O in region 1, byte granularity
    wr(1, 32'hA01C_0280);
    sel(1);
    rq(32'h0000_0280, 1, "R6");
    rq(32'h0000_0287, 1, "R6");
    rq(32'h0000_0288, 1, "R6");
    rq(32'h0000_0284, 0, "R7");   // memory access ignores an I/O region

    // R5 low I/O region, then hole redirect
    wr(3, 32'h207C_0300);
    rq(32'hABCD_0300, 1, "R5");
    rq(32'h0000_031F, 1, "R5");
    wr(8, 32'h8000_0100);
    sel(8);
    rq(32'h0000_03B0, 1, "R4");
    rq(32'h0000_0000, 1, "R4");
    rq(32'h0000_0310, 1, "R5");
    rq(32'h0000_0320, 1, "R4");

    // R8 PCI codes outside regions 0 and 1
    wr(4, 32'h6200_0020);
    wr(5, 32'hA03C_0200);
    rq(32'h0020_0000, 0, "R8");
    rq(32'h0000_0205, 1, "R8");
    wr(8, 32'h0000_0100);
    rq(32'h0000_0205, 1, "R8");

    // R9 overlap priority, 4 KB granularity
    wr(2, 32'h480C_0100);
    wr(6, 32'h943C_0100);
    sel(6);
    rq(32'h0010_1000, 0, "R9");
    rq(32'h0010_3FFF, 0, "R9");
    rq(32'h0010_4000, 0, "R9");
    rq(32'h0010_FFFF, 0, "R9");
    rq(32'h0011_0000, 0, "R6");

    // R7 disabled codes
    wr(7, 32'hC3FC_0000);
    rq(32'h0005_0000, 0, "R7");
    wr(7, 32'hE3FC_0000);
    rq(32'h0005_0000, 0, "R7");
    wr(0, 32'h0204_000A);
    rq(32'h000A_0000, 0, "R7");

    // R12 stray index, ceiling move, write and request in one cycle
    wr(12, 32'hFFFF_FFFF);
    sel(12);
    rq(32'h0000_0300, 1, "R12");
    wr(8, 32'h0000_0200);
    rq(32'h0180_0000, 0, "R12");
    #1; regWe = 1; regAddr = 4'd8; regWdata = 32'h0000_0100;
    curTag = "R12"; reqValid = 1; reqAddr = 32'h0180_0000; reqIsIo = 0;
    @(negedge clk);
    #1; regWe = 0; reqValid = 0;
    rq(32'h0180_0000, 0, "R12");

    // R11 back-to-back then idle
    rq(32'h0000_0400, 1, "R11");
    rq(32'h0010_1000, 0, "R11");
    sel(2);
    sel(2);

    summary();
  end

endmodule